// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block turns parallel left/right audio sample pairs into a three-wire serial stream: a bit clock, a word-select line that marks the channel, and a serial data line. Each frame holds 64 bit clocks, 32 per channel, with the left channel first. At run time the block can send either the I2S framing, where the MSB leads one bit clock after the word-select change, or a right-justified framing, where the LSB falls on the last bit clock of the slot. Right-justified words can be 18 or 16 bits wide. I2S always sends 18 bits.

The bit clock is divided down from the system clock. Its rate follows the sample-rate select: fs, 2fs or 4fs. Upstream logic presents a sample pair with a valid flag. The block takes the pair only at a frame boundary and signals the take with a one-cycle ready pulse. All framing settings (format, width, rate and the two polarity inversions) are sampled at that same boundary, so a frame is never split between two settings. A CD-ROM mode input holds the data line low from the next bit clock on.

Top module: `serial_audio_tx`

## Requirements
- R1: During and right after reset, sclkOut, wsOut, sdOut and sampleReady are all low.
- R2: The bit clock period is 2·BASE_HALF·M system clocks, where rateSel 0 (fs) gives M=4, 1 (2fs) gives M=2, and 2 or 3 (4fs) give M=1. Sclk, word select and data change only on a falling edge of sclkOut. A frame is 64 bit clocks. With no inversion, word select is low for the 32 left bits (frame bits 0–31) and high for the 32 right bits (frame bits 32–63).
- R3: With rightJust=0 (I2S), slot bit 1 carries sample bit 17 and slot bits 1–18 carry bits 17 down to 0. All other slot bits are 0, and wide18 has no effect.
- R4: With rightJust=1, the word ends with its LSB on slot bit 31. With wide18=1, slot bits 14–31 carry sample bits 17..0. With wide18=0, slot bits 16–31 carry sample bits 17..2. Earlier slot bits are 0.
- R5: With wsInvert=1, word select is high in the left half of the frame and low in the right half.
- R6: With dataInvert=1, every data bit of the frame, padding included, is the complement of its non-inverted value.
- R7: With cdromMode=1, sdOut is low at every bit clock, whatever dataInvert is.
- R8: sampleReady is a one-cycle pulse issued once per frame, at the cycle in which the frame's first bit is launched. The interval between pulses is 64 bit-clock periods. If sampleValid is high in that cycle, that cycle's pair is the one the new frame sends.
- R9: If sampleValid is low at the boundary, the new frame sends all-zero samples.
- R10: A change of rightJust, wide18, rateSel, wsInvert or dataInvert during a frame leaves that frame unchanged. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 2 | Sample rate: 0 fs, 1 2fs, 2/3 4fs |
| rightJust | input | 1 | 1 selects right-justified framing, 0 selects I2S |
| wide18 | input | 1 | Right-justified word width: 1 gives 18 bits, 0 gives 16 |
| wsInvert | input | 1 | Inverts word select |
| dataInvert | input | 1 | Inverts serial data |
| cdromMode | input | 1 | Holds serial data low |
| sampleValid | input | 1 | Sample pair present |
| sampleLeft | input | 18 | Left sample, MSB-aligned |
| sampleRight | input | 18 | Right sample, MSB-aligned |
| sampleReady | output | 1 | Pair taken this cycle (frame boundary) |
| sclkOut | output | 1 | Serial bit clock |
| wsOut | output | 1 | Word select |
| sdOut | output | 1 | Serial data |

## Verification
The bench builds the block with BASE_HALF=1. This gives bit clock periods of 8, 4 and 2 system clocks, so a whole frame lasts at most 512 cycles. Each format, width, polarity and rate combination can then be captured bit by bit across complete frames. Because the divisor is small, the short 4fs period, the aliased rate code 3 and a configuration change in the middle of a frame can all be checked within a few thousand cycles.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int SAMPLE_W   = 18;
  localparam int NARROW_W   = 16;
  localparam int SLOT_BITS  = 32;
  localparam int SLOT_W     = $clog2(SLOT_BITS);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int FRAME_W    = $clog2(FRAME_BITS);

  typedef struct packed {
    logic rightJust;
    logic wide18;
    logic wsInv;
    logic dataInv;
  } frameCfg_t;

  typedef struct packed {
    logic              fallTick;
    logic              frameTick;
    logic              nextRight;
    logic [SLOT_W-1:0] nextBit;
  } strobe_t;
endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rateSel,
  output strobe_t    strb,
  output logic       sclkOut,
  output logic       sampleReady
);
  localparam int DIV_W = $clog2(4 * BASE_HALF + 1);
  localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   halfLen;
  logic [1:0]         rateReg;
  logic               sclkReg;
  logic [FRAME_W-1:0] bitIdx;
  logic [FRAME_W-1:0] nextIdx;
  logic               edgeNow;
  logic               fallTick;
  logic               frameTick;

  always_comb begin
    case (rateReg)
      2'd0:    halfLen = DIV_W'(4 * BASE_HALF);
      2'd1:    halfLen = DIV_W'(2 * BASE_HALF);
      default: halfLen = DIV_W'(BASE_HALF);
    endcase
  end

  assign edgeNow   = (divCnt == halfLen - DIV_W'(1));
  assign fallTick  = edgeNow && sclkReg;
  assign frameTick = fallTick && (bitIdx == FRAME_LAST);
  assign nextIdx   = bitIdx + FRAME_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
      bitIdx  <= FRAME_LAST;
      rateReg <= 2'd0;
    end else begin
      if (edgeNow) begin
        divCnt  <= '0;
        sclkReg <= ~sclkReg;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
      if (fallTick)  bitIdx  <= nextIdx;
      if (frameTick) rateReg <= rateSel;
    end
  end

  assign strb.fallTick  = fallTick;
  assign strb.frameTick = frameTick;
  assign strb.nextRight = nextIdx[FRAME_W-1];
  assign strb.nextBit   = nextIdx[SLOT_W-1:0];
  assign sclkOut        = sclkReg;
  assign sampleReady    = frameTick;

  assert_sclk_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sclkOut) |-> $past(strb.fallTick));

  assert_ready_single_R8: assert property (@(posedge clk) disable iff (rst)
    sampleReady |=> !sampleReady);
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  frameCfg_t           cfgIn,
  input  logic                cdromMode,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                wsOut,
  output logic                sdOut
);
  frameCfg_t           cfgReg;
  frameCfg_t           cfgEff;
  logic [SAMPLE_W-1:0] leftReg;
  logic [SAMPLE_W-1:0] rightReg;
  logic [SAMPLE_W-1:0] word;
  logic [5:0]          firstBit;
  logic [5:0]          winLen;
  logic [5:0]          kExt;
  logic [5:0]          offs;
  logic [4:0]          srcIdx;
  logic                inWin;
  logic                rawBit;

  // Settings sampled at the boundary steer the first bit of the new frame
  assign cfgEff = strb.frameTick ? cfgIn : cfgReg;
  assign word   = strb.nextRight ? rightReg : leftReg;

  always_comb begin
    if (!cfgEff.rightJust) begin
      winLen   = 6'(SAMPLE_W);
      firstBit = 6'd1;
    end else begin
      winLen   = cfgEff.wide18 ? 6'(SAMPLE_W) : 6'(NARROW_W);
      firstBit = 6'(SLOT_BITS) - winLen;
    end
    kExt   = {1'b0, strb.nextBit};
    inWin  = (kExt >= firstBit) && (kExt < firstBit + winLen);
    offs   = kExt - firstBit;
    srcIdx = 5'(SAMPLE_W - 1) - offs[4:0];
    rawBit = inWin ? word[srcIdx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg   <= '0;
      leftReg  <= '0;
      rightReg <= '0;
      wsOut    <= 1'b0;
      sdOut    <= 1'b0;
    end else begin
      if (strb.frameTick) begin
        cfgReg   <= cfgIn;
        leftReg  <= sampleValid ? sampleLeft  : '0;
        rightReg <= sampleValid ? sampleRight : '0;
      end
      if (strb.fallTick) begin
        wsOut <= strb.nextRight ^ cfgEff.wsInv;
        sdOut <= cdromMode ? 1'b0 : (rawBit ^ cfgEff.dataInv);
      end
    end
  end

  assert_edge_align_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wsOut) || !$stable(sdOut)) |-> $past(strb.fallTick));

  assert_cdrom_mute_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(strb.fallTick) && $past(cdromMode)) |-> !sdOut);
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int BASE_HALF = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          rateSel,
  input  logic                rightJust,
  input  logic                wide18,
  input  logic                wsInvert,
  input  logic                dataInvert,
  input  logic                cdromMode,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                sampleReady,
  output logic                sclkOut,
  output logic                wsOut,
  output logic                sdOut
);
  strobe_t   strb;
  frameCfg_t cfgIn;

  assign cfgIn.rightJust = rightJust;
  assign cfgIn.wide18    = wide18;
  assign cfgIn.wsInv     = wsInvert;
  assign cfgIn.dataInv   = dataInvert;

  sat_ctrl #(.BASE_HALF(BASE_HALF)) u_ctrl (
    .clk(clk), .rst(rst), .rateSel(rateSel),
    .strb(strb), .sclkOut(sclkOut), .sampleReady(sampleReady)
  );

  sat_datapath u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cfgIn(cfgIn),
    .cdromMode(cdromMode), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .wsOut(wsOut), .sdOut(sdOut)
  );
endmodule

// File: tb/tb_serial_audio_tx.sv
module tb_serial_audio_tx;
  localparam int BH = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rateSel = 2'd0;
  logic rightJust = 1'b0, wide18 = 1'b0, wsInvert = 1'b0, dataInvert = 1'b0;
  logic cdromMode = 1'b0, sampleValid = 1'b0;
  logic [17:0] sampleLeft = '0, sampleRight = '0;
  logic sampleReady, sclkOut, wsOut, sdOut;

  int vectors = 0;
  int misses = 0;
  logic [63:0] capSd, capWs;
  int capPeriod;

  serial_audio_tx #(.BASE_HALF(BH)) dut (
    .clk(clk), .rst(rst), .rateSel(rateSel), .rightJust(rightJust),
    .wide18(wide18), .wsInvert(wsInvert), .dataInvert(dataInvert),
    .cdromMode(cdromMode), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleReady(sampleReady), .sclkOut(sclkOut), .wsOut(wsOut), .sdOut(sdOut)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int periodOf(input logic [1:0] r);
    return 2 * BH * ((r == 2'd0) ? 4 : (r == 2'd1) ? 2 : 1);
  endfunction

  function automatic logic [63:0] expSd(input logic rj, input logic w18, input logic dinv,
                                        input logic cd, input logic [17:0] l, input logic [17:0] r);
    logic [63:0] v;
    int w, first;
    w = rj ? (w18 ? 18 : 16) : 18;
    first = rj ? 32 - w : 1;
    for (int k = 0; k < 64; k++) begin
      int b;
      logic bitv;
      logic [17:0] wd;
      b = k % 32;
      wd = (k >= 32) ? r : l;
      bitv = (b >= first && b < first + w) ? wd[17 - (b - first)] : 1'b0;
      v[k] = cd ? 1'b0 : (bitv ^ dinv);
    end
    return v;
  endfunction

  function automatic logic [63:0] expWs(input logic inv);
    return inv ? {32'h0, 32'hFFFF_FFFF} : {32'hFFFF_FFFF, 32'h0};
  endfunction

  task automatic waitReady();
    do @(negedge clk); while (!sampleReady);
  endtask

  // Capture one frame after a ready pulse; optionally flip settings mid-frame
  task automatic captureFrame(input int flipAt);
    logic prev;
    int rises, lastRise, cyc;
    prev = sclkOut;
    rises = 0; lastRise = 0; cyc = 0; capPeriod = 0;
    while (rises < 64) begin
      @(negedge clk);
      cyc++;
      if (sclkOut && !prev) begin
        capSd[rises] = sdOut;
        capWs[rises] = wsOut;
        if (rises > 0) capPeriod = cyc - lastRise;
        lastRise = cyc;
        rises++;
        if (rises == flipAt) begin
          rightJust = ~rightJust;
          dataInvert = ~dataInvert;
          rateSel = 2'd2;
        end
      end
      prev = sclkOut;
    end
  endtask

  task automatic runFrame(input string req, input logic [1:0] rt, input logic rj, input logic w18,
                          input logic wi, input logic di, input logic cd, input logic vld,
                          input logic [17:0] l, input logic [17:0] r);
    @(negedge clk);
    rateSel = rt; rightJust = rj; wide18 = w18; wsInvert = wi; dataInvert = di;
    cdromMode = cd; sampleValid = vld; sampleLeft = l; sampleRight = r;
    waitReady();
    captureFrame(-1);
    check({req, " data"}, capSd, expSd(rj, w18, di, cd, vld ? l : 18'h0, vld ? r : 18'h0));
    check({req, " ws R2/R5"}, capWs, expWs(wi));
    check({req, " period R2"}, 64'(capPeriod), 64'(periodOf(rt)));
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset outputs", {60'h0, sclkOut, wsOut, sdOut, sampleReady}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {60'h0, sclkOut, wsOut, sdOut, sampleReady}, 64'h0);
  endtask

  task automatic testI2s();
    runFrame("R3 i2s fs", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h2_A5C3, 18'h1_3F0E);
    runFrame("R3 i2s w18 ignored", 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 18'h3_0001, 18'h0_8000);
  endtask

  task automatic testRightJust();
    runFrame("R4 rj18 2fs", 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 18'h2_5A5B, 18'h1_C3C1);
    runFrame("R4 rj16 4fs", 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h3_FFFD, 18'h0_0007);
    runFrame("R2 rate code3", 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h1_2345, 18'h2_3456);
  endtask

  task automatic testPolarity();
    runFrame("R5 ws invert", 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 18'h0_F0F0, 18'h3_0F0F);
    runFrame("R6 data invert", 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h1_1111, 18'h2_2222);
  endtask

  task automatic testMute();
    runFrame("R7 cdrom mute", 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 18'h3_FFFF, 18'h3_FFFF);
  endtask

  task automatic testNoValid();
    runFrame("R9 no valid", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3_ABCD, 18'h1_DCBA);
  endtask

  task automatic testReady();
    int gap;
    @(negedge clk);
    rateSel = 2'd1; sampleValid = 1'b1;
    waitReady();
    waitReady();
    @(negedge clk);
    check("R8 ready one cycle", 64'(sampleReady), 64'h0);
    gap = 1;
    while (!sampleReady) begin
      @(negedge clk);
      gap++;
    end
    check("R8 ready interval", 64'(gap), 64'(64 * periodOf(2'd1)));
  endtask

  task automatic testMidFrame();
    logic [17:0] l, r;
    l = 18'h2_7E81; r = 18'h1_0F3C;
    @(negedge clk);
    rateSel = 2'd1; rightJust = 1'b0; wide18 = 1'b1; wsInvert = 1'b0; dataInvert = 1'b0;
    cdromMode = 1'b0; sampleValid = 1'b1; sampleLeft = l; sampleRight = r;
    waitReady();
    waitReady();
    captureFrame(10);
    check("R10 frame unchanged", capSd, expSd(1'b0, 1'b1, 1'b0, 1'b0, l, r));
    check("R10 period unchanged", 64'(capPeriod), 64'(periodOf(2'd1)));
    waitReady();
    captureFrame(-1);
    check("R10 next frame new cfg", capSd, expSd(1'b1, 1'b1, 1'b1, 1'b0, l, r));
    check("R10 next frame new rate", 64'(capPeriod), 64'(periodOf(2'd2)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    testReset();
    testI2s();
    testRightJust();
    testPolarity();
    testMute();
    testNoValid();
    testReady();
    testMidFrame();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule